// File: doc/BRIEF.md
# Real-Mode Segment Address Generator

This block holds the six segment registers of a 32-bit processor while it runs in its 8086-compatible addressing mode. Each register has a 16-bit selector that software can see and a hidden base and limit. A request names a segment and gives an offset. The block then returns the linear address, which is the hidden base plus the offset. It also flags any offset that lies beyond the 64 KB segment limit.

Reset puts the registers into a special state. The code segment shows selector 0xF000, but its hidden base is set to 0xFFFF0000 rather than being derived from the selector. This makes the first instruction fetch, at offset 0xFFF0, land just below the top of the 4 GB space. A selector write makes the normal rule apply to that register from then on: the hidden base becomes the selector shifted left by four bits. A separate read port returns the selector of any register.

Top module: `segAddrGen`

## Requirements
- R1: While reset is held and after it is released, segment index 0 (code) reads selector 0xF000 and uses base 0xFFFF0000. An offset of 0xFFF0 on index 0 therefore yields linear address 0xFFFFFFF0.
- R2: After reset, segment indices 1 to 5 read selector 0x0000 and use base 0, so the linear address equals the offset.
- R3: From the clock edge that takes a write to index k (0 to 5) onward, a request on k yields (selector << 4) + offset, with the selector zero-extended to 32 bits.
- R4: Index 0 keeps base 0xFFFF0000 until index 0 itself is written, whatever writes reach indices 1 to 5.
- R5: A write takes effect on the next rising edge. A request in the same cycle as the write still sees the old selector and base.
- R6: limitViol is 1 when the offset exceeds 0xFFFF and 0 when the offset is 0xFFFF or less, for indices 0 to 5.
- R7: rdSel returns the current selector of the register named by rdIdx.
- R8: Indices 6 and 7 name no register. Writes to them change nothing, rdSel returns 0 for them, and a request on them raises limitViol.
- R9: The linear address is the 32-bit sum truncated to 32 bits, so it wraps past 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Selector write strobe |
| wrIdx | input | 3 | Index of the register to write |
| wrSel | input | 16 | Selector value to write |
| reqIdx | input | 3 | Segment index of the address request |
| reqOff | input | 32 | Offset of the address request |
| rdIdx | input | 3 | Index of the selector to read |
| linAddr | output | 32 | Linear address (base plus offset) |
| limitViol | output | 1 | Offset beyond the limit, or request on an invalid index |
| rdSel | output | 16 | Selector of the register named by rdIdx |

## Verification
The bench builds the block with its default parameters: six registers, 16-bit selectors, a 32-bit address, a shift of four and a limit of 0xFFFF. With these values every index code can be driven, including the two codes that name no register. These defaults also make the top-of-memory reset base wrap to zero with a modest offset, and they place the limit boundary at 0xFFFF/0x10000. A behavioural model in the bench is compared on every cycle during directed and random traffic. The traffic includes writes and requests to the same register in the same cycle, and a second reset in mid-run.

// File: rtl/segPkg.sv
package segPkg;
  localparam int SEG_COUNT = 6;
  localparam int CODE_IDX  = 0;

  typedef struct packed {
    logic [SEG_COUNT-1:0] load;
    logic                 reqValid;
    logic                 rdValid;
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output segStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      strobes.load[i] = wrEn && (wrIdx == IDX_W'(i));
      if (reqIdx == IDX_W'(i)) strobes.reqValid = 1'b1;
      if (rdIdx == IDX_W'(i))  strobes.rdValid  = 1'b1;
    end
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          SEL_W      = 16,
  parameter int          IDX_W      = 3,
  parameter int          SHIFT      = 4,
  parameter int unsigned LIMIT      = 'hFFFF,
  parameter int unsigned CODE_SEL0  = 'hF000,
  parameter int unsigned CODE_BASE0 = 'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobes_t       strobes,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [ADDR_W-1:0] reqOff,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] linAddr,
  output logic              limitViol,
  output logic [SEL_W-1:0]  rdSel
);
  localparam logic [ADDR_W-1:0] LIMIT_V   = ADDR_W'(LIMIT);
  localparam logic [ADDR_W-1:0] NEW_BASE0 = '0;

  logic [SEL_W-1:0]  selQ   [SEG_COUNT];
  logic [ADDR_W-1:0] baseQ  [SEG_COUNT];
  logic [ADDR_W-1:0] limitQ [SEG_COUNT];
  logic [ADDR_W-1:0] shiftedSel;

  assign shiftedSel = {{(ADDR_W-SEL_W){1'b0}}, wrSel} << SHIFT;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : gSeg
    localparam logic [SEL_W-1:0]  RST_SEL  = (i == CODE_IDX) ? SEL_W'(CODE_SEL0)   : '0;
    localparam logic [ADDR_W-1:0] RST_BASE = (i == CODE_IDX) ? ADDR_W'(CODE_BASE0) : NEW_BASE0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ[i]   <= RST_SEL;
        baseQ[i]  <= RST_BASE;
        limitQ[i] <= LIMIT_V;
      end else if (strobes.load[i]) begin
        selQ[i]   <= wrSel;
        baseQ[i]  <= shiftedSel;
        limitQ[i] <= LIMIT_V;
      end
    end
  end

  logic [ADDR_W-1:0] curBase, curLimit;
  always_comb begin
    curBase  = '0;
    curLimit = '0;
    rdSel    = '0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (reqIdx == IDX_W'(i)) begin
        curBase  = baseQ[i];
        curLimit = limitQ[i];
      end
      if (rdIdx == IDX_W'(i)) rdSel = selQ[i];
    end
  end

  assign linAddr   = curBase + reqOff;
  assign limitViol = !strobes.reqValid || (reqOff > curLimit);
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segPkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          SEL_W      = 16,
  parameter int          IDX_W      = 3,
  parameter int          SHIFT      = 4,
  parameter int unsigned LIMIT      = 'hFFFF,
  parameter int unsigned CODE_SEL0  = 'hF000,
  parameter int unsigned CODE_BASE0 = 'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [ADDR_W-1:0] reqOff,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] linAddr,
  output logic              limitViol,
  output logic [SEL_W-1:0]  rdSel
);
  segStrobes_t strobes;

  segCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .reqIdx(reqIdx), .rdIdx(rdIdx), .strobes(strobes)
  );

  segDatapath #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .SHIFT(SHIFT),
    .LIMIT(LIMIT), .CODE_SEL0(CODE_SEL0), .CODE_BASE0(CODE_BASE0)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrSel(wrSel),
    .reqIdx(reqIdx), .reqOff(reqOff), .rdIdx(rdIdx),
    .linAddr(linAddr), .limitViol(limitViol), .rdSel(rdSel)
  );
endmodule

// File: rtl/segAddrGenChecker.sv
module segAddrGenChecker #(
  parameter int          ADDR_W = 32,
  parameter int          SEL_W  = 16,
  parameter int          IDX_W  = 3,
  parameter int          SHIFT  = 4,
  parameter int unsigned LIMIT  = 'hFFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [SEL_W-1:0]  wrSel,
  input logic [IDX_W-1:0]  reqIdx,
  input logic [ADDR_W-1:0] reqOff,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [ADDR_W-1:0] linAddr,
  input logic              limitViol,
  input logic [SEL_W-1:0]  rdSel
);
  localparam int SEGS = segPkg::SEG_COUNT;

  // R7: a valid write is visible on the read port one edge later
  assert_sel_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrIdx) < SEGS) |=> (rdIdx != $past(wrIdx) || rdSel == $past(wrSel)));

  // R3: a valid write sets the base by the shift rule
  assert_shift_rule_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrIdx) < SEGS) |=> (reqIdx != $past(wrIdx) ||
      linAddr == (({{(ADDR_W-SEL_W){1'b0}}, $past(wrSel)} << SHIFT) + reqOff)));

  // R6: limit flag on valid indices
  assert_limit_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(reqIdx) < SEGS) |-> (limitViol == (reqOff > ADDR_W'(LIMIT))));

  // R8: invalid request index always flagged
  assert_bad_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(reqIdx) >= SEGS) |-> limitViol);

  // R8: invalid read index returns zero
  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdIdx) >= SEGS) |-> (rdSel == '0));

  // R1: code selector during reset
  always @(negedge clk) begin
    if (!rstN && rdIdx == '0)
      assert_reset_code_R1: assert (rdSel == SEL_W'('hF000));
  end
endmodule

bind segAddrGen segAddrGenChecker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .SHIFT(SHIFT), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrSel(wrSel),
  .reqIdx(reqIdx), .reqOff(reqOff), .rdIdx(rdIdx),
  .linAddr(linAddr), .limitViol(limitViol), .rdSel(rdSel)
);

// File: tb/segAddrGen_bench.sv
module segAddrGen_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [2:0]  wrIdx = 0;
  logic [15:0] wrSel = 0;
  logic [2:0]  reqIdx = 0;
  logic [31:0] reqOff = 0;
  logic [2:0]  rdIdx = 0;
  logic [31:0] linAddr;
  logic        limitViol;
  logic [15:0] rdSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mSel [8];
  logic [31:0] mBase [8];

  always #5 clk = ~clk;

  segAddrGen u_segAddrGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrSel(wrSel),
    .reqIdx(reqIdx), .reqOff(reqOff), .rdIdx(rdIdx),
    .linAddr(linAddr), .limitViol(limitViol), .rdSel(rdSel)
  );

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mSel[i]  = 16'h0;
      mBase[i] = 32'h0;
    end
    mSel[0]  = 16'hF000;
    mBase[0] = 32'hFFFF0000;
  endtask

  initial modelReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else if (wrEn && wrIdx < 3'd6) begin
      mSel[wrIdx]  = wrSel;
      mBase[wrIdx] = {12'h0, wrSel, 4'h0};
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare all outputs with the model
  task automatic modelCompare(string tag);
    logic [31:0] expAddr;
    logic        expViol;
    logic [15:0] expRd;
    if (reqIdx < 3'd6) begin
      expAddr = mBase[reqIdx] + reqOff;
      expViol = reqOff > 32'hFFFF;
      chk(tag, linAddr, expAddr);
    end else begin
      expViol = 1'b1;
    end
    expRd = (rdIdx < 3'd6) ? mSel[rdIdx] : 16'h0;
    chk(tag, {31'h0, limitViol}, {31'h0, expViol});
    chk(tag, {16'h0, rdSel}, {16'h0, expRd});
  endtask

  task automatic drive(logic we, logic [2:0] wi, logic [15:0] ws,
                       logic [2:0] ri, logic [31:0] ro, logic [2:0] di);
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrSel = ws; reqIdx = ri; reqOff = ro; rdIdx = di;
    #1;
  endtask

  initial begin
    // R1 R2: reset state, sampled while reset is held
    drive(0, 0, 0, 0, 32'hFFF0, 0);
    chk("R1 reset fetch", linAddr, 32'hFFFFFFF0);
    chk("R1 reset sel", {16'h0, rdSel}, 32'h0000F000);
    @(negedge clk); rstN = 1;
    for (int i = 1; i < 6; i++) begin
      drive(0, 0, 0, 3'(i), 32'h1234, 3'(i));
      chk("R2 data base zero", linAddr, 32'h1234);
      chk("R2 data sel zero", {16'h0, rdSel}, 32'h0);
    end

    // R5: write seg1 with same-cycle request sees old base
    drive(1, 1, 16'h1234, 1, 32'h10, 1);
    chk("R5 old base", linAddr, 32'h10);
    chk("R5 old sel", {16'h0, rdSel}, 32'h0);
    drive(0, 0, 0, 1, 32'h10, 1);
    chk("R3 new base", linAddr, 32'h00012350);
    chk("R7 readback", {16'h0, rdSel}, 32'h1234);

    // R4: writes to other segments leave code reset base
    drive(1, 3, 16'hABCD, 0, 32'hFFF0, 3);
    drive(1, 5, 16'hFFFF, 0, 32'hFFF0, 5);
    drive(0, 0, 0, 0, 32'hFFF0, 5);
    chk("R4 code base kept", linAddr, 32'hFFFFFFF0);
    chk("R7 seg5 sel", {16'h0, rdSel}, 32'hFFFF);
    drive(0, 0, 0, 5, 32'hFFFF, 0);
    chk("R3 max base", linAddr, 32'h0010FFEF);
    chk("R6 at limit", {31'h0, limitViol}, 32'h0);

    // R6 R9: above limit and wrap
    drive(0, 0, 0, 0, 32'h10000, 0);
    chk("R6 over limit", {31'h0, limitViol}, 32'h1);
    chk("R9 wrap", linAddr, 32'h0);

    // R8: invalid indices
    drive(1, 6, 16'h5555, 6, 32'h0, 6);
    chk("R8 bad req flag", {31'h0, limitViol}, 32'h1);
    drive(1, 7, 16'h7777, 7, 32'h0, 7);
    chk("R8 bad read zero", {16'h0, rdSel}, 32'h0);
    drive(0, 0, 0, 2, 32'h0, 2);
    chk("R8 no side effect", {16'h0, rdSel}, 32'h0);

    // R4 R5: first code write, same-cycle old base
    drive(1, 0, 16'h0800, 0, 32'hFFF0, 0);
    chk("R5 code old base", linAddr, 32'hFFFFFFF0);
    drive(0, 0, 0, 0, 32'hFFF0, 0);
    chk("R4 code normal rule", linAddr, 32'h00017FF0);
    chk("R7 code sel", {16'h0, rdSel}, 32'h0800);

    // R3 R7 R6 R8: random traffic vs model
    for (int n = 0; n < 400; n++) begin
      drive(1'($urandom), 3'($urandom), 16'($urandom), 3'($urandom),
            ($urandom % 4 == 0) ? $urandom : 32'($urandom % 32'h10000),
            3'($urandom));
      modelCompare("R3 random");
    end

    // R1: second reset restores special code state
    @(negedge clk); rstN = 0;
    drive(0, 0, 0, 0, 32'hFFF0, 0);
    chk("R1 re-reset fetch", linAddr, 32'hFFFFFFF0);
    @(negedge clk); rstN = 1;
    drive(0, 0, 0, 1, 32'h0, 1);
    chk("R2 re-reset data", {16'h0, rdSel}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule